// File: doc/BRIEF.md
# Asymmetric Output Mute Controller

This block sits on the PCM sample path directly after a sample-rate converter and decides how loud each output sample may be. Whenever the upstream data is flagged as unusable, the block silences the stream immediately. When all problems have cleared, it brings the signal back gradually. The gain climbs linearly from zero to full scale in 4095 steps. It advances by one step for each output sample, so the fade-in lasts about 4096 output-sample periods whatever the master clock rate is.

The upstream logic supplies a strobe for each output sample, a signed 24-bit sample and a vector of error sources. Examples of error sources are lock loss and an unsupported rate. If any one of them is high, the data counts as invalid. The block returns the scaled sample one clock after its strobe. It also reports whether the output is fully muted or still fading in.

Scaling multiplies the signed sample by the unsigned 12-bit gain and divides by 4096, truncating toward zero. A sample and its negation therefore always give outputs of equal size and opposite sign. At the top gain value the sample passes through bit-exact.

Top module: `amute_ctrl`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `out_sample` is 0, `out_stb` is 0, `muted` is 1 and `ramping` is 0; the gain restarts at 0.
- R2: `out_stb` equals `in_stb` delayed by exactly one clock. `out_sample` is updated on that same edge.
- R3: On a strobe with every error bit low, `out_sample` = trunc-toward-zero(sample × g / 4096), where g is the gain before the strobe. After that strobe g rises by one.
- R4: When g is 4095, a valid strobe passes the sample through unchanged and g stays at 4095.
- R5: On a strobe with any bit of `err_src` high, `out_sample` is 0 (hard mute, no ramp).
- R6: Any error bit high on any clock, with or without a strobe, returns g to 0. The first valid sample after recovery is therefore output as 0.
- R7: `muted` is 1 exactly when g is 0. `ramping` is 1 exactly when g is between 1 and 4094. Both are 0 at g = 4095.
- R8: Negative samples scale symmetrically. During the ramp a negative sample never gives a positive output, and a sample of -1 at a small gain gives 0, not -1.
- R9: Starting from mute, 4095 consecutive valid strobes reach full gain. The ramp counts output strobes, not clock cycles.
- R10: A clock without a strobe leaves `out_sample` and the gain unchanged while the data is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_stb | input | 1 | One-cycle strobe per output sample |
| in_sample | input | 24 | Signed two's-complement sample from the converter |
| err_src | input | NUM_ERR (3) | Error sources; any bit high marks the data invalid |
| out_stb | output | 1 | `in_stb` delayed one clock |
| out_sample | output | 24 | Gain-scaled signed sample |
| muted | output | 1 | Gain is zero |
| ramping | output | 1 | Gain is between the ends of the fade |

## Verification
The bench walks the complete fade from zero to full gain against its own gain model. A design that timed the ramp in clocks, or stopped one step short, would give a wrong value at some sample or never pass samples through unchanged. It feeds -1 at small gains and -4096 at gain 2: a floor shift would give -1 instead of 0, and a wrong sign extension would turn the output positive. An error pulse placed between strobes shows whether the gain is cleared at once or only on the next strobe. Single error bits at both ends of the vector check that every source counts.

// File: rtl/amute_pkg.sv
package amute_pkg;

    localparam int SAMPLE_W = 24;
    localparam int GAIN_W   = 12;
    localparam int PROD_W   = SAMPLE_W + GAIN_W + 1;

    localparam logic [GAIN_W-1:0] GAIN_ZERO = '0;
    localparam logic [GAIN_W-1:0] GAIN_FULL = '1;
    localparam logic [PROD_W-1:0] TRUNC_BIAS = PROD_W'((1 << GAIN_W) - 1);

    typedef logic signed [SAMPLE_W-1:0] sample_t;
    typedef logic [GAIN_W-1:0]          gain_t;
    typedef logic signed [PROD_W-1:0]   prod_t;

    typedef enum logic [1:0] {
        LVL_MUTE = 2'd0,
        LVL_RAMP = 2'd1,
        LVL_FULL = 2'd2
    } level_e;

    typedef struct packed {
        logic    stb;
        sample_t data;
    } beat_t;

    function automatic level_e classify(input gain_t g);
        if (g == GAIN_ZERO)      return LVL_MUTE;
        else if (g == GAIN_FULL) return LVL_FULL;
        else                     return LVL_RAMP;
    endfunction

endpackage

// File: rtl/amute_valid_merge.sv
module amute_valid_merge
    #(parameter int NUM_ERR = 3)
(
    input  logic [NUM_ERR-1:0] err_src,
    output logic               data_ok
);
    generate
        if (NUM_ERR == 1) begin : g_single
            assign data_ok = ~err_src[0];
        end else begin : g_many
            logic [NUM_ERR-1:0] any_err;
            for (genvar i = 0; i < NUM_ERR; i++) begin : g_chain
                if (i == 0) begin : g_first
                    assign any_err[i] = err_src[i];
                end else begin : g_next
                    assign any_err[i] = any_err[i-1] | err_src[i];
                end
            end
            assign data_ok = ~any_err[NUM_ERR-1];
        end
    endgenerate
endmodule

// File: rtl/amute_gain_ctrl.sv
module amute_gain_ctrl
    import amute_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   data_ok,
    input  logic   smp_stb,
    output gain_t  gain,
    output logic   muted,
    output logic   ramping
);
    level_e level;

    always_ff @(posedge clk) begin
        if (rst)
            gain <= GAIN_ZERO;
        else if (!data_ok)
            gain <= GAIN_ZERO;
        else if (smp_stb && gain != GAIN_FULL)
            gain <= gain + 1'b1;
    end

    always_comb begin
        level   = classify(gain);
        muted   = (level == LVL_MUTE);
        ramping = (level == LVL_RAMP);
    end

    // R6
    err_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !data_ok |=> muted);

    // R3
    step_up_chk: assert property (@(posedge clk) disable iff (rst)
        (data_ok && smp_stb && !muted && ramping) |=> gain == $past(gain) + 1'b1);

    // R4
    full_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (data_ok && !muted && !ramping) |=> (!muted && !ramping));

    // R7
    ramp_enter_chk: assert property (@(posedge clk) disable iff (rst)
        (data_ok && smp_stb && muted) |=> ramping);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (data_ok && !smp_stb) |=> $stable(gain));
endmodule

// File: rtl/amute_scaler.sv
module amute_scaler
    import amute_pkg::*;
(
    input  sample_t smp_in,
    input  gain_t   gain,
    output sample_t smp_out
);
    prod_t product;
    prod_t biased;
    prod_t shifted;

    always_comb begin
        product = prod_t'(smp_in) * $signed({1'b0, gain});
        biased  = product[PROD_W-1] ? product + $signed(TRUNC_BIAS) : product;
        shifted = biased >>> GAIN_W;
        if (gain == GAIN_FULL)
            smp_out = smp_in;
        else
            smp_out = sample_t'(shifted);
    end

    always_comb begin
        if (!$isunknown(gain) && !$isunknown(smp_in)) begin
            // R8
            sign_keep_chk: assert (!(smp_in >= 0 && smp_out < 0) && !(smp_in < 0 && smp_out > 0));
        end
    end
endmodule

// File: rtl/amute_ctrl.sv
module amute_ctrl
    import amute_pkg::*;
    #(parameter int NUM_ERR = 3)
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_stb,
    input  logic [SAMPLE_W-1:0] in_sample,
    input  logic [NUM_ERR-1:0]  err_src,
    output logic                out_stb,
    output logic [SAMPLE_W-1:0] out_sample,
    output logic                muted,
    output logic                ramping
);
    logic    data_ok;
    gain_t   gain;
    sample_t scaled;
    beat_t   in_beat;
    beat_t   out_beat;

    assign in_beat.stb  = in_stb;
    assign in_beat.data = sample_t'(in_sample);

    amute_valid_merge #(.NUM_ERR(NUM_ERR)) u_merge (
        .err_src (err_src),
        .data_ok (data_ok)
    );

    amute_gain_ctrl u_gain (
        .clk     (clk),
        .rst     (rst),
        .data_ok (data_ok),
        .smp_stb (in_beat.stb),
        .gain    (gain),
        .muted   (muted),
        .ramping (ramping)
    );

    amute_scaler u_scale (
        .smp_in  (in_beat.data),
        .gain    (gain),
        .smp_out (scaled)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_beat <= '0;
        end else begin
            out_beat.stb <= in_beat.stb;
            if (in_beat.stb)
                out_beat.data <= data_ok ? scaled : '0;
        end
    end

    assign out_stb    = out_beat.stb;
    assign out_sample = out_beat.data;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (out_sample == '0 && !out_stb && muted));

    // R2
    stb_delay_chk: assert property (@(posedge clk) disable iff (rst)
        in_stb |=> out_stb);

    // R2
    stb_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_stb |=> !out_stb);

    // R5
    hard_mute_chk: assert property (@(posedge clk) disable iff (rst)
        (in_stb && (|err_src)) |=> out_sample == '0);

    // R10
    hold_out_chk: assert property (@(posedge clk) disable iff (rst)
        !in_stb |=> $stable(out_sample));
endmodule

// File: tb/amute_ctrl_tb_top.sv
module amute_ctrl_tb_top;
    localparam int NE = 3;
    localparam int NV = 11;
    localparam int FULL = 4095;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_stb = 1'b0;
    logic [23:0]   in_sample = '0;
    logic [NE-1:0] err_src = '0;
    logic          out_stb;
    logic [23:0]   out_sample;
    logic          muted;
    logic          ramping;

    int n_chk = 0;
    int n_bad = 0;
    int mgain = 0;

    always #4 clk = ~clk;

    amute_ctrl #(.NUM_ERR(NE)) dut_i (
        .clk(clk), .rst(rst), .in_stb(in_stb), .in_sample(in_sample),
        .err_src(err_src), .out_stb(out_stb), .out_sample(out_sample),
        .muted(muted), .ramping(ramping)
    );

    // stimulus: strobe, sample, error bits; expected: sample, muted
    localparam int V_STB [NV] = '{1, 1, 1, 1, 0, 1, 1, 1, 1, 1, 1};
    localparam int V_SMP [NV] = '{1000, 2097152, -4096, -1, 999, 40960, 5000, 7, -2097152, 4096, 4096};
    localparam int V_ERR [NV] = '{0, 0, 0, 0, 0, 0, 1, 0, 4, 0, 0};
    localparam int V_EXP [NV] = '{0, 512, -2, 0, 0, 40, 0, 0, 0, 0, 1};
    localparam int V_MUT [NV] = '{0, 0, 0, 0, 0, 0, 1, 0, 1, 0, 0};

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input logic s, input int smp, input logic [NE-1:0] e);
        @(negedge clk);
        in_stb    = s;
        in_sample = 24'(smp);
        err_src   = e;
        @(negedge clk);
        in_stb    = 1'b0;
    endtask

    function automatic int model_out(input int s, input int g);
        longint p;
        if (g == FULL) return s;
        p = longint'(s) * longint'(g);
        return int'(p / 4096);
    endfunction

    function automatic int outv();
        return int'($signed(out_sample));
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_stb = 1'b0; err_src = '0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        mgain = 0;
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int e;
        // R1 reset state
        @(negedge clk); @(negedge clk);
        check("R1 out_sample", outv(), 0);
        check("R1 out_stb", int'(out_stb), 0);
        check("R1 muted", int'(muted), 1);
        check("R1 ramping", int'(ramping), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 out_sample after release", outv(), 0);

        // table walk (R2, R3, R5, R6, R8, R10)
        for (int i = 0; i < NV; i++) begin
            step(V_STB[i] != 0, V_SMP[i], NE'(V_ERR[i]));
            check($sformatf("R2 vector %0d strobe", i), int'(out_stb), V_STB[i]);
            check($sformatf("R3 R5 vector %0d sample", i), outv(), V_EXP[i]);
            check($sformatf("R6 vector %0d muted", i), int'(muted), V_MUT[i]);
        end

        // R9 full fade from mute, with R3 R7 R8 per step
        do_reset();
        for (int i = 0; i < FULL; i++) begin
            int s = (i % 2 == 1) ? -1234567 - i : 1234567 + i;
            step(1'b1, s, '0);
            e = model_out(s, mgain);
            check("R3 ramp sample", outv(), e);
            if (s < 0 && outv() > 0) check("R8 sign", outv(), e);
            mgain++;
            check("R7 muted", int'(muted), 0);
            check("R7 ramping", int'(ramping), (mgain < FULL) ? 1 : 0);
        end
        check("R9 full after 4095 strobes", int'(ramping), 0);
        // R4 pass-through
        step(1'b1, -8388608, '0);
        check("R4 min passthrough", outv(), -8388608);
        step(1'b1, 8388607, '0);
        check("R4 max passthrough", outv(), 8388607);
        check("R4 stays full muted", int'(muted), 0);
        check("R4 stays full ramping", int'(ramping), 0);

        // R10 idle clocks hold output
        step(1'b0, 12345, '0);
        check("R10 hold sample", outv(), 8388607);
        check("R10 no strobe", int'(out_stb), 0);

        // R6 error between strobes, mid-ramp
        do_reset();
        for (int i = 0; i < 200; i++) step(1'b1, 100, '0);
        step(1'b0, 0, 3'b010);
        check("R6 muted after idle error", int'(muted), 1);
        step(1'b1, 4194304, '0);
        check("R6 restart from zero", outv(), 0);
        step(1'b1, 4194304, '0);
        check("R6 second step gain 1", outv(), 1024);

        // R5 each single error source
        for (int b = 0; b < NE; b++) begin
            step(1'b1, 4194304, NE'(1 << b));
            check($sformatf("R5 err bit %0d", b), outv(), 0);
            check($sformatf("R6 err bit %0d muted", b), int'(muted), 1);
        end

        // R8 small negative sample truncates toward zero
        step(1'b1, -1, '0);
        step(1'b1, -1, '0);
        check("R8 minus one at gain 1", outv(), 0);

        // R1 reset mid-stream
        for (int i = 0; i < 10; i++) step(1'b1, 300000, '0);
        @(negedge clk);
        rst = 1'b1; in_stb = 1'b1;
        @(negedge clk);
        check("R1 mid reset sample", outv(), 0);
        check("R1 mid reset strobe", int'(out_stb), 0);
        check("R1 mid reset muted", int'(muted), 1);
        rst = 1'b0; in_stb = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule